// File: doc/BRIEF.md
# Masked-Write General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port on a simple 32-bit register bus. Every pin has an output value, an output-enable and a synchronized input level. Software makes a pin an output or an input through two separate write-one registers, so it never has to read and rewrite a shared direction word. When a bit is written as one, the pin changes. When a bit is written as zero, nothing happens.

The output values are held in two half-width data registers. One covers pins 0 to 15 and the other covers pins 16 to 31. Each write to a data register carries its own bit mask in the upper half-word, and the data sits in the lower half-word. A single pin can therefore change value in one bus write, while its neighbours keep theirs. The data registers keep their contents while a pin is still an input. This lets software preload the level a pin will drive and only then turn its driver on.

The pin inputs pass through a two-flop synchronizer before they can be read back. Read data is registered and appears one cycle after the address is presented.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is high and after it, every output-enable is 0, every output value is 0, and read data is 0.
- R2: A write to offset 0x00 sets output-enable for every pin whose data bit is 1, effective on the next clock edge. Bits written as 0 leave that pin's output-enable unchanged.
- R3: A write to offset 0x04 clears output-enable for every pin whose data bit is 1. Bits written as 0 leave that pin's output-enable unchanged.
- R4: A write to offset 0x08 updates the output value of pin n (n = 0..15) to write-data bit n only where mask bit 16+n is 1. All other pins keep their value.
- R5: A write to offset 0x0C updates the output value of pin 16+n (n = 0..15) to write-data bit n only where mask bit 16+n is 1. All other pins keep their value.
- R6: Output values are stored and driven on the value pins whatever the output-enable state, and they are not altered when the direction changes.
- R7: A read of offset 0x10 returns the pin input levels through two synchronizer flops plus the read register. A level applied before clock edge k is first visible on read data after edge k+2, and not after edge k+1.
- R8: Read data is registered one cycle after the address. Offsets 0x00 and 0x04 return the 32-bit output-enable state. Offset 0x08 returns pins 0..15 output values in bits 15:0, and offset 0x0C returns pins 16..31 output values in bits 15:0. The upper bits are 0 for both data offsets.
- R9: Writes to any other offset change no output-enable or output value, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output-enable per pin, 1 drives the pin |
| pin_in | input | 32 | Raw pin input levels |

## Verification
The hardest case to reach from the ports is a masked data write in which the masked-off bits carry data that differs from the stored value. A design that ignores the mask looks correct whenever data and stored value agree. The stimulus therefore walks a single mask bit across each half while writing the inverse of the stored pattern. It also runs a long pseudo-random sequence in which the mask, the data and the direction words are independent. A second hard point is the exact synchronizer latency. The bench holds the input read address and samples read data after the second and after the third clock edge following a pin change.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int BUS_W   = 32;
  localparam int MASK_LO = 16;
  localparam logic [7:0] OFS_DIR_SET = 8'h00;
  localparam logic [7:0] OFS_DIR_CLR = 8'h04;
  localparam logic [7:0] OFS_OUT_LO  = 8'h08;
  localparam logic [7:0] OFS_OUT_HI  = 8'h0C;
  localparam logic [7:0] OFS_PIN_IN  = 8'h10;
endpackage

// File: rtl/gpio_dir_ctrl.sv
module gpio_dir_ctrl #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [NPINS-1:0] bits,
  output logic [NPINS-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (set_stb) begin
      dir_q <= dir_q | bits;
    end else if (clr_stb) begin
      dir_q <= dir_q & ~bits;
    end
  end
endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half #(
  parameter int HALF = 16,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_stb,
  input  logic [DW-1:0]   wdata,
  output logic [HALF-1:0] val_q
);
  localparam int MPOS = DW / 2;

  logic [HALF-1:0] mask;
  logic [HALF-1:0] data;

  assign mask = wdata[MPOS +: HALF];
  assign data = wdata[0 +: HALF];

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else if (wr_stb) begin
      val_q <= (val_q & ~mask) | (data & mask);
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] synced
);
  logic [NPINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  pin_in
);
  localparam int HALF  = NPINS / 2;
  localparam int NHALF = 2;

  logic             hit_set, hit_clr, hit_lo, hit_hi, hit_in;
  logic [HALF-1:0]  half_val [NHALF];
  logic [NPINS-1:0] in_sync;
  logic [BUS_W-1:0] rd_d;

  assign hit_set = (bus_addr == ADDR_W'(OFS_DIR_SET));
  assign hit_clr = (bus_addr == ADDR_W'(OFS_DIR_CLR));
  assign hit_lo  = (bus_addr == ADDR_W'(OFS_OUT_LO));
  assign hit_hi  = (bus_addr == ADDR_W'(OFS_OUT_HI));
  assign hit_in  = (bus_addr == ADDR_W'(OFS_PIN_IN));

  gpio_dir_ctrl #(.NPINS(NPINS)) u_dir (
    .clk     (clk),
    .rst     (rst),
    .set_stb (bus_we & hit_set),
    .clr_stb (bus_we & hit_clr),
    .bits    (bus_wdata[NPINS-1:0]),
    .dir_q   (pin_oe)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic sel;
    if (h == 0) begin : g_lo
      assign sel = hit_lo;
    end else begin : g_hi
      assign sel = hit_hi;
    end
    gpio_out_half #(.HALF(HALF), .DW(BUS_W)) u_half (
      .clk    (clk),
      .rst    (rst),
      .wr_stb (bus_we & sel),
      .wdata  (bus_wdata),
      .val_q  (half_val[h])
    );
    assign pin_out[h*HALF +: HALF] = half_val[h];
  end

  gpio_in_sync #(.NPINS(NPINS), .STAGES(STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    (pin_in),
    .synced (in_sync)
  );

  always_comb begin
    rd_d = '0;
    if (hit_set || hit_clr) rd_d[NPINS-1:0] = pin_oe;
    else if (hit_lo)        rd_d[HALF-1:0]  = half_val[0];
    else if (hit_hi)        rd_d[HALF-1:0]  = half_val[1];
    else if (hit_in)        rd_d[NPINS-1:0] = in_sync;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
  import gpio_mask_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe
);
  localparam int HALF = NPINS / 2;

  logic w_set, w_clr, w_lo, w_hi;
  assign w_set = bus_we && bus_addr == ADDR_W'(OFS_DIR_SET);
  assign w_clr = bus_we && bus_addr == ADDR_W'(OFS_DIR_CLR);
  assign w_lo  = bus_we && bus_addr == ADDR_W'(OFS_OUT_LO);
  assign w_hi  = bus_we && bus_addr == ADDR_W'(OFS_OUT_HI);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (pin_oe == '0 && pin_out == '0 && bus_rdata == '0)); // R1
  AST_DIR_SET_BITS: assert property (@(posedge clk) disable iff (rst)
    w_set |=> ((pin_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))); // R2
  AST_DIR_SET_KEEP: assert property (@(posedge clk) disable iff (rst)
    w_set |=> (((pin_oe ^ $past(pin_oe)) & ~$past(bus_wdata[NPINS-1:0])) == '0)); // R2
  AST_DIR_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
    w_clr |=> ((pin_oe & $past(bus_wdata[NPINS-1:0])) == '0)); // R3
  AST_DIR_CLR_KEEP: assert property (@(posedge clk) disable iff (rst)
    w_clr |=> (((pin_oe ^ $past(pin_oe)) & ~$past(bus_wdata[NPINS-1:0])) == '0)); // R3
  AST_LO_MASKED: assert property (@(posedge clk) disable iff (rst)
    w_lo |=> (((pin_out[HALF-1:0] ^ $past(pin_out[HALF-1:0])) & ~$past(bus_wdata[16 +: HALF])) == '0
              && $stable(pin_out[NPINS-1:HALF]))); // R4
  AST_HI_MASKED: assert property (@(posedge clk) disable iff (rst)
    w_hi |=> (((pin_out[NPINS-1:HALF] ^ $past(pin_out[NPINS-1:HALF])) & ~$past(bus_wdata[16 +: HALF])) == '0
              && $stable(pin_out[HALF-1:0]))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(w_lo || w_hi) |=> $stable(pin_out)); // R6
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(w_set || w_clr) |=> $stable(pin_oe)); // R9
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_out, pin_oe;
  logic [31:0] pin_in = '0;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_dir = '0;
  logic [31:0] m_out = '0;
  logic [31:0] lcg = 32'h1234_5678;
  logic [31:0] rv;

  always #10 clk = ~clk;

  gpio_mask_port u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      8'h00: m_dir = m_dir | d;
      8'h04: m_dir = m_dir & ~d;
      8'h08: m_out[15:0]  = (m_out[15:0]  & ~d[31:16]) | (d[15:0] & d[31:16]);
      8'h0C: m_out[31:16] = (m_out[31:16] & ~d[31:16]) | (d[15:0] & d[31:16]);
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic cmp_state(input string req);
    check({req, " oe"}, pin_oe, m_dir);
    check({req, " out"}, pin_out, m_out);
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00, 8'h04: return m_dir;
      8'h08: return {16'h0, m_out[15:0]};
      8'h0C: return {16'h0, m_out[31:16]};
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 oe", pin_oe, 32'h0);
    check("R1 out", pin_out, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R6: preload output while input, then enable driver
    wr(8'h08, 32'hFFFF_A5C3);
    check("R6 preload out", pin_out, 32'h0000_A5C3);
    check("R6 still input", pin_oe, 32'h0);
    wr(8'h00, 32'h0000_FFFF);
    check("R6 value kept on enable", pin_out, 32'h0000_A5C3);
    wr(8'h04, 32'hFFFF_FFFF);
    cmp_state("R6 after disable");

    // R2/R3: walking single bits, zeros have no effect
    for (int i = 0; i < 32; i++) begin
      wr(8'h00, 32'h1 << i);
      check("R2 walk set", pin_oe, m_dir);
    end
    wr(8'h00, 32'h0);
    check("R2 zero write", pin_oe, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i += 2) begin
      wr(8'h04, 32'h1 << i);
      check("R3 walk clear", pin_oe, m_dir);
    end
    wr(8'h04, 32'h0);
    check("R3 zero write", pin_oe, 32'hAAAA_AAAA);

    // R4/R5: single mask bit, inverse data elsewhere
    for (int i = 0; i < 16; i++) begin
      wr(8'h08, {16'h1 << i, ~m_out[15:0]});
      check("R4 walk mask", pin_out, m_out);
      wr(8'h0C, {16'h1 << i, ~m_out[31:16]});
      check("R5 walk mask", pin_out, m_out);
    end
    wr(8'h08, {16'h0, 16'hFFFF});
    check("R4 empty mask", pin_out, m_out);
    wr(8'h0C, {16'h0, ~m_out[31:16]});
    check("R5 empty mask", pin_out, m_out);

    // R8: read-back of every control offset
    foreach (d[k]) if (k < 1) ;
    rd(8'h00, d); check("R8 read dir set ofs", d, exp_rd(8'h00));
    rd(8'h04, d); check("R8 read dir clr ofs", d, exp_rd(8'h04));
    rd(8'h08, d); check("R8 read out lo", d, exp_rd(8'h08));
    rd(8'h0C, d); check("R8 read out hi", d, exp_rd(8'h0C));

    // R9: unmapped offsets
    for (int a = 20; a < 64; a += 4) begin
      wr(8'(a), 32'hFFFF_FFFF);
      cmp_state("R9 unmapped write");
      rd(8'(a), d);
      check("R9 unmapped read", d, 32'h0);
    end

    // Pseudo-random sweep (R2 R3 R4 R5 R8)
    for (int k = 0; k < 400; k++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      rv = lcg ^ (lcg >> 13);
      case (k % 5)
        0: begin wr(8'h00, rv); cmp_state("R2 sweep"); end
        1: begin wr(8'h04, rv); cmp_state("R3 sweep"); end
        2: begin wr(8'h08, rv); cmp_state("R4 sweep"); end
        3: begin wr(8'h0C, rv); cmp_state("R5 sweep"); end
        default: begin
          rd({4'h0, rv[1:0], 2'b00}, d);
          check("R8 sweep read", d, exp_rd({4'h0, rv[1:0], 2'b00}));
        end
      endcase
    end

    // R7: synchronizer latency on the input register
    for (int k = 0; k < 4; k++) begin
      logic [31:0] old_v, new_v;
      old_v = pin_in;
      new_v = (k == 3) ? 32'h0 : {k[7:0], 8'h5A, 8'hC3, ~k[7:0]} ^ 32'hF0F0_0F0F;
      bus_addr = 8'h10;
      @(negedge clk); @(negedge clk); @(negedge clk);
      check("R7 settled", bus_rdata, old_v);
      pin_in = new_v;
      @(negedge clk); @(negedge clk);
      check("R7 not yet visible", bus_rdata, old_v);
      @(negedge clk);
      check("R7 visible after sync", bus_rdata, new_v);
    end

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    m_dir = '0; m_out = '0;
    cmp_state("R1 reset again");
    check("R1 rdata again", bus_rdata, 32'h0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule